// File: doc/BRIEF.md
# Reset Controller Register Block

This block is the software-visible register file of a chip reset controller. It keeps a sticky record of why the device last came out of reset. That record covers power-on, exit from low power, a software request, and a set of hardware request sources. Software can ask for a full system reset by writing a 4-bit multi-bit boolean. The request is held until the sequencer reports that the reset is complete, and the field then returns to its false code without software action.

The block drives a bank of active-low software reset lines, one for each peripheral. Each line has its own lock bit. Once a lock bit is cleared, that line can no longer change. Two crash-dump readout windows, one for alerts and one for the CPU, each have a capture enable and a word index behind their own lock. Any system reset turns the capture enables off. The attribute and data words of each window are read from inputs supplied by the dump storage. The block also has a write-only alert test register and a read-only word of sticky error flags.

Access uses a single-cycle 32-bit write strobe with a byte address. Reads are combinational from the address.

Top module: `rstctl_regs`

## Requirements
- R1: After block reset the following values hold. Cause word (0x08) = 0x01. Request field (0x04) = 0x9. Every lock word (0x0C, 0x1C, and 0x2C+4*i) = 1. Every sw_rst_n bit = 1. Dump control words (0x10, 0x20) = 0. Error word (0x6C) = 0. sys_rst_req = 0.
- R2: A write to 0x04 stores bits 3:0 in the request field. sys_rst_req is 1 exactly while the field holds 0x6. Any other code, for example 0x5, leaves sys_rst_req at 0.
- R3: A pulse on rst_done_evt returns the request field to 0x9. If the field held 0x6 when the pulse arrived, bit 2 of the cause word is also set.
- R4: In the cause word, bits 2:0 are cleared by writing 1 to them. A write never changes bits 7:3.
- R5: lp_exit_evt sets cause bit 1. hw_req_evt[k] sets cause bit 3+k. These bits stay set until cleared. When a set and a write-1 clear of the same bit happen in the same cycle, the set wins.
- R6: Writing 0 in bit 0 of a lock word clears that lock. Writing 1 has no effect. A cleared lock stays 0 until block reset.
- R7: Bit 0 of software reset word 0x4C+4*i drives sw_rst_n[i]. 0 holds module i in reset and 1 releases it. The write is ignored while lock word 0x2C+4*i is 0. Each channel is independent of the others.
- R8: In dump control words 0x10 (alert) and 0x20 (CPU), bit 0 is the capture enable and bits 7:4 are the word index. Both appear on the matching output ports and read back in the same positions.
- R9: A write to a dump control word is ignored while that window's lock (0x0C for alert, 0x1C for CPU) is 0. The other window is unaffected.
- R10: A sys_rst_evt pulse clears both capture enables and keeps both indices. It wins over a write in the same cycle, but the index from that write is still taken.
- R11: 0x14 and 0x24 read the available word count in bits 3:0. 0x18 and 0x28 read the current dump data word of their window.
- R12: A write to 0x00 with bit 0 set makes fatal_alert_pulse 1 for one cycle, in the cycle after the write. Bit 1 does the same for cnsty_alert_pulse. Reads of 0x00 return 0.
- R13: err_evt[k] sets bit k of the error word (0x6C). The bits stay set until block reset, and writes do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of this block |
| sys_rst_evt | input | 1 | One-cycle pulse: a system reset has occurred |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| lp_exit_evt | input | 1 | Low-power-exit cause event |
| hw_req_evt | input | 5 | Hardware reset request cause events |
| rst_done_evt | input | 1 | Requested reset has completed |
| err_evt | input | 3 | Error events (integrity, consistency, FSM) |
| alert_dump_cnt | input | 4 | Words available in alert dump |
| alert_dump_word | input | 32 | Alert dump word at current index |
| cpu_dump_cnt | input | 4 | Words available in CPU dump |
| cpu_dump_word | input | 32 | CPU dump word at current index |
| sys_rst_req | output | 1 | System reset request to power control |
| fatal_alert_pulse | output | 1 | Fatal-fault alert test pulse |
| cnsty_alert_pulse | output | 1 | Consistency-fault alert test pulse |
| sw_rst_n | output | 8 | Active-low software resets |
| alert_dump_en | output | 1 | Alert dump capture enable |
| alert_dump_idx | output | 4 | Alert dump read index |
| cpu_dump_en | output | 1 | CPU dump capture enable |
| cpu_dump_idx | output | 4 | CPU dump read index |

## Verification
The request field is given a non-true code, then the true code, then a completion pulse. This separates a plain stored value from a real request, and shows whether completion logs a software cause. Cause bits are driven three ways: write-1 clears alone, event pulses alone, and a clear and a set of the same bit in one cycle. This shows whether clears are limited to bits 2:0 and whether the set wins. Locks are exercised by clearing one software-reset channel and one dump window and then writing to them, with a neighbouring channel or window written as a control. System reset pulses are sent both alone and together with a dump control write.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int DATA_W = 32;

  typedef logic [3:0] mubi4_t;
  localparam mubi4_t MUBI4_TRUE  = 4'h6;
  localparam mubi4_t MUBI4_FALSE = 4'h9;

  // byte offsets; software decodes these
  localparam logic [7:0] OFF_ATEST     = 8'h00;
  localparam logic [7:0] OFF_REQ       = 8'h04;
  localparam logic [7:0] OFF_CAUSE     = 8'h08;
  localparam logic [7:0] OFF_ALOCK     = 8'h0C;
  localparam logic [7:0] OFF_ACTRL     = 8'h10;
  localparam logic [7:0] OFF_AATTR     = 8'h14;
  localparam logic [7:0] OFF_ADATA     = 8'h18;
  localparam logic [7:0] OFF_CLOCK     = 8'h1C;
  localparam logic [7:0] OFF_CCTRL     = 8'h20;
  localparam logic [7:0] OFF_CATTR     = 8'h24;
  localparam logic [7:0] OFF_CDATA     = 8'h28;
  localparam logic [7:0] OFF_SWLOCK0   = 8'h2C;
  localparam logic [7:0] OFF_SWCTRL0   = 8'h4C;
  localparam logic [7:0] OFF_ERR       = 8'h6C;

  function automatic logic mubi_is_true(input mubi4_t v);
    return v == MUBI4_TRUE;
  endfunction

  // address of element i of a word array starting at base
  function automatic logic [7:0] word_addr(input logic [7:0] base, input int i);
    return base + 8'(4 * i);
  endfunction

  // sticky update: set has priority over clear
  function automatic logic [15:0] sticky_next(input logic [15:0] cur,
                                              input logic [15:0] set,
                                              input logic [15:0] clr);
    return (cur & ~clr) | set;
  endfunction

  // write-zero-to-clear lock update
  function automatic logic lock_next(input logic cur, input logic wr, input logic wbit);
    return cur & ~(wr & ~wbit);
  endfunction
endpackage

// File: rtl/rstctl_lock.sv
module rstctl_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wbit,
  output logic lock_q
);
  import rstctl_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else        lock_q <= lock_next(lock_q, wr_en, wbit);
  end

  // R6: once cleared the lock cannot be set again
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q);
endmodule

// File: rtl/rstctl_swrst_bank.sv
module rstctl_swrst_bank #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] lock_wr,
  input  logic [N_CH-1:0] ctrl_wr,
  input  logic            wbit,
  output logic [N_CH-1:0] lock_q,
  output logic [N_CH-1:0] rst_n_q
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic accept;

    rstctl_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (lock_wr[i]),
      .wbit   (wbit),
      .lock_q (lock_q[i])
    );

    assign accept = ctrl_wr[i] & lock_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rst_n_q[i] <= 1'b1;
      else if (accept) rst_n_q[i] <= wbit;
    end

    // R7: a locked channel does not move
    a_r7_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_q[i] |=> $stable(rst_n_q[i]));
  end
endmodule

// File: rtl/rstctl_dump_ctl.sv
module rstctl_dump_ctl #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst_evt,
  input  logic             lock_wr,
  input  logic             ctrl_wr,
  input  logic             lock_wbit,
  input  logic             en_wbit,
  input  logic [IDX_W-1:0] idx_wdata,
  output logic             lock_q,
  output logic             en_q,
  output logic [IDX_W-1:0] idx_q
);
  logic accept;

  rstctl_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (lock_wr),
    .wbit   (lock_wbit),
    .lock_q (lock_q)
  );

  assign accept = ctrl_wr & lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      if (sys_rst_evt) en_q <= 1'b0;
      else if (accept) en_q <= en_wbit;
      if (accept)      idx_q <= idx_wdata;
    end
  end

  // R10: system reset always drops the capture enable
  a_r10_sysrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_evt |=> !en_q);
  // R9: locked window index stays put
  a_r9_locked_idx: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> $stable(idx_q));
endmodule

// File: rtl/rstctl_cause_log.sv
module rstctl_cause_log #(
  parameter int N_HW  = 5,
  parameter int N_ERR = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_wr,
  input  logic                     cause_wr,
  input  logic [3:0]               req_wdata,
  input  logic [2:0]               cause_w1c,
  input  logic                     lp_exit_evt,
  input  logic [N_HW-1:0]          hw_req_evt,
  input  logic                     rst_done_evt,
  input  logic [N_ERR-1:0]         err_evt,
  output rstctl_pkg::mubi4_t       req_q,
  output logic [3+N_HW-1:0]        cause_q,
  output logic [N_ERR-1:0]         err_q
);
  import rstctl_pkg::*;

  localparam int CAUSE_W = 3 + N_HW;

  logic [CAUSE_W-1:0] cause_set, cause_clr;
  logic               sw_cause_evt;

  assign sw_cause_evt = rst_done_evt & mubi_is_true(req_q);
  assign cause_set    = {hw_req_evt, sw_cause_evt, lp_exit_evt, 1'b0};
  assign cause_clr    = cause_wr ? CAUSE_W'(cause_w1c) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= MUBI4_FALSE;
      cause_q <= CAUSE_W'(1);
      err_q   <= '0;
    end else begin
      if (rst_done_evt) req_q <= MUBI4_FALSE;
      else if (req_wr)  req_q <= mubi4_t'(req_wdata);
      cause_q <= CAUSE_W'(sticky_next(16'(cause_q), 16'(cause_set), 16'(cause_clr)));
      err_q   <= N_ERR'(sticky_next(16'(err_q), 16'(err_evt), 16'h0));
    end
  end

  // R3: completion returns the field to false
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done_evt |=> req_q == MUBI4_FALSE);
  // R5: an event wins over a same-cycle clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit_evt |=> cause_q[1]);
  // R4: hardware source bits never drop
  a_r4_hw_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q[CAUSE_W-1:3] & $past(cause_q[CAUSE_W-1:3])) == $past(cause_q[CAUSE_W-1:3])));
  // R13: error flags are sticky
  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs #(
  parameter int ADDR_W   = 8,
  parameter int N_SWRST  = 8,
  parameter int N_HW_REQ = 5,
  parameter int N_ERR    = 3,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sys_rst_evt,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                lp_exit_evt,
  input  logic [N_HW_REQ-1:0] hw_req_evt,
  input  logic                rst_done_evt,
  input  logic [N_ERR-1:0]    err_evt,
  input  logic [CNT_W-1:0]    alert_dump_cnt,
  input  logic [31:0]         alert_dump_word,
  input  logic [CNT_W-1:0]    cpu_dump_cnt,
  input  logic [31:0]         cpu_dump_word,
  output logic                sys_rst_req,
  output logic                fatal_alert_pulse,
  output logic                cnsty_alert_pulse,
  output logic [N_SWRST-1:0]  sw_rst_n,
  output logic                alert_dump_en,
  output logic [IDX_W-1:0]    alert_dump_idx,
  output logic                cpu_dump_en,
  output logic [IDX_W-1:0]    cpu_dump_idx
);
  import rstctl_pkg::*;

  localparam int CAUSE_W = 3 + N_HW_REQ;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // named write events
  logic wr_atest, wr_req, wr_cause, wr_alock, wr_actrl, wr_clock, wr_cctrl;
  logic [N_SWRST-1:0] wr_swlock, wr_swctrl;

  assign wr_atest = reg_wr & hit(reg_addr, OFF_ATEST);
  assign wr_req   = reg_wr & hit(reg_addr, OFF_REQ);
  assign wr_cause = reg_wr & hit(reg_addr, OFF_CAUSE);
  assign wr_alock = reg_wr & hit(reg_addr, OFF_ALOCK);
  assign wr_actrl = reg_wr & hit(reg_addr, OFF_ACTRL);
  assign wr_clock = reg_wr & hit(reg_addr, OFF_CLOCK);
  assign wr_cctrl = reg_wr & hit(reg_addr, OFF_CCTRL);

  for (genvar i = 0; i < N_SWRST; i++) begin : g_dec
    assign wr_swlock[i] = reg_wr & hit(reg_addr, word_addr(OFF_SWLOCK0, i));
    assign wr_swctrl[i] = reg_wr & hit(reg_addr, word_addr(OFF_SWCTRL0, i));
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[31:8];

  // cause, request, error
  mubi4_t             req_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [N_ERR-1:0]   err_q;

  rstctl_cause_log #(.N_HW(N_HW_REQ), .N_ERR(N_ERR)) u_cause (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_wr       (wr_req),
    .cause_wr     (wr_cause),
    .req_wdata    (reg_wdata[3:0]),
    .cause_w1c    (reg_wdata[2:0]),
    .lp_exit_evt  (lp_exit_evt),
    .hw_req_evt   (hw_req_evt),
    .rst_done_evt (rst_done_evt),
    .err_evt      (err_evt),
    .req_q        (req_q),
    .cause_q      (cause_q),
    .err_q        (err_q)
  );

  assign sys_rst_req = mubi_is_true(req_q);

  // software reset bank
  logic [N_SWRST-1:0] swlock_q;

  rstctl_swrst_bank #(.N_CH(N_SWRST)) u_swrst (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_wr (wr_swlock),
    .ctrl_wr (wr_swctrl),
    .wbit    (reg_wdata[0]),
    .lock_q  (swlock_q),
    .rst_n_q (sw_rst_n)
  );

  // dump windows
  logic alock_q, clock_q;

  rstctl_dump_ctl #(.IDX_W(IDX_W)) u_adump (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_evt (sys_rst_evt),
    .lock_wr     (wr_alock),
    .ctrl_wr     (wr_actrl),
    .lock_wbit   (reg_wdata[0]),
    .en_wbit     (reg_wdata[0]),
    .idx_wdata   (reg_wdata[4 +: IDX_W]),
    .lock_q      (alock_q),
    .en_q        (alert_dump_en),
    .idx_q       (alert_dump_idx)
  );

  rstctl_dump_ctl #(.IDX_W(IDX_W)) u_cdump (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_evt (sys_rst_evt),
    .lock_wr     (wr_clock),
    .ctrl_wr     (wr_cctrl),
    .lock_wbit   (reg_wdata[0]),
    .en_wbit     (reg_wdata[0]),
    .idx_wdata   (reg_wdata[4 +: IDX_W]),
    .lock_q      (clock_q),
    .en_q        (cpu_dump_en),
    .idx_q       (cpu_dump_idx)
  );

  // alert test pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fatal_alert_pulse <= 1'b0;
      cnsty_alert_pulse <= 1'b0;
    end else begin
      fatal_alert_pulse <= wr_atest & reg_wdata[0];
      cnsty_alert_pulse <= wr_atest & reg_wdata[1];
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, OFF_REQ))   reg_rdata = 32'(req_q);
    if (hit(reg_addr, OFF_CAUSE)) reg_rdata = 32'(cause_q);
    if (hit(reg_addr, OFF_ALOCK)) reg_rdata = 32'(alock_q);
    if (hit(reg_addr, OFF_ACTRL)) reg_rdata = 32'({alert_dump_idx, 3'b000, alert_dump_en});
    if (hit(reg_addr, OFF_AATTR)) reg_rdata = 32'(alert_dump_cnt);
    if (hit(reg_addr, OFF_ADATA)) reg_rdata = alert_dump_word;
    if (hit(reg_addr, OFF_CLOCK)) reg_rdata = 32'(clock_q);
    if (hit(reg_addr, OFF_CCTRL)) reg_rdata = 32'({cpu_dump_idx, 3'b000, cpu_dump_en});
    if (hit(reg_addr, OFF_CATTR)) reg_rdata = 32'(cpu_dump_cnt);
    if (hit(reg_addr, OFF_CDATA)) reg_rdata = cpu_dump_word;
    if (hit(reg_addr, OFF_ERR))   reg_rdata = 32'(err_q);
    for (int i = 0; i < N_SWRST; i++) begin
      if (hit(reg_addr, word_addr(OFF_SWLOCK0, i))) reg_rdata = 32'(swlock_q[i]);
      if (hit(reg_addr, word_addr(OFF_SWCTRL0, i))) reg_rdata = 32'(sw_rst_n[i]);
    end
  end

  // R12: each test pulse traces back to a test write
  a_r12_fatal_src: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_alert_pulse |-> $past(wr_atest && reg_wdata[0]));
  a_r12_cnsty_src: assert property (@(posedge clk) disable iff (!rst_n)
    cnsty_alert_pulse |-> $past(wr_atest && reg_wdata[1]));
  // R2: a request only rises after a request write
  a_r2_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(wr_req));
endmodule

// File: tb/rstctl_regs_tb.sv
module rstctl_regs_tb;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_rst_evt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lp_exit_evt = 1'b0;
  logic [4:0]  hw_req_evt = '0;
  logic        rst_done_evt = 1'b0;
  logic [2:0]  err_evt = '0;
  logic [3:0]  alert_dump_cnt = '0;
  logic [31:0] alert_dump_word = '0;
  logic [3:0]  cpu_dump_cnt = '0;
  logic [31:0] cpu_dump_word = '0;
  logic        sys_rst_req, fatal_alert_pulse, cnsty_alert_pulse;
  logic [7:0]  sw_rst_n;
  logic        alert_dump_en, cpu_dump_en;
  logic [3:0]  alert_dump_idx, cpu_dump_idx;

  always #(CLK_T/2) clk = ~clk;

  rstctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .sys_rst_evt(sys_rst_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lp_exit_evt(lp_exit_evt), .hw_req_evt(hw_req_evt), .rst_done_evt(rst_done_evt),
    .err_evt(err_evt),
    .alert_dump_cnt(alert_dump_cnt), .alert_dump_word(alert_dump_word),
    .cpu_dump_cnt(cpu_dump_cnt), .cpu_dump_word(cpu_dump_word),
    .sys_rst_req(sys_rst_req), .fatal_alert_pulse(fatal_alert_pulse),
    .cnsty_alert_pulse(cnsty_alert_pulse), .sw_rst_n(sw_rst_n),
    .alert_dump_en(alert_dump_en), .alert_dump_idx(alert_dump_idx),
    .cpu_dump_en(cpu_dump_en), .cpu_dump_idx(cpu_dump_idx)
  );

  // probe kinds
  localparam int P_RDATA = 0, P_REQ = 1, P_SWRST = 2, P_PULSE = 3, P_ADUMP = 4, P_CDUMP = 5;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  function automatic logic [31:0] probe(input int kind);
    case (kind)
      P_RDATA: return reg_rdata;
      P_REQ:   return 32'(sys_rst_req);
      P_SWRST: return 32'(sw_rst_n);
      P_PULSE: return 32'({cnsty_alert_pulse, fatal_alert_pulse});
      P_ADUMP: return 32'({alert_dump_idx, alert_dump_en});
      default: return 32'({cpu_dump_idx, cpu_dump_en});
    endcase
  endfunction

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      sb_item_t it;
      logic [31:0] got;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      #1;
      got = probe(it.kind);
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic expect_port(input int kind, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    #2;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    expect_port(P_RDATA, exp, tag);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [7:0] swl(input int i); return 8'h2C + 8'(4*i); endfunction
  function automatic logic [7:0] swc(input int i); return 8'h4C + 8'(4*i); endfunction

  // watchdog
  initial begin
    #(CLK_T * 20000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    expect_rd(8'h08, 32'h01, "R1 cause");
    expect_rd(8'h04, 32'h09, "R1 request");
    expect_rd(8'h0C, 32'h1, "R1 alert lock");
    expect_rd(8'h1C, 32'h1, "R1 cpu lock");
    expect_rd(swl(3), 32'h1, "R1 sw lock 3");
    expect_port(P_SWRST, 32'hFF, "R1 sw_rst_n");
    expect_rd(8'h10, 32'h0, "R1 alert ctrl");
    expect_rd(8'h6C, 32'h0, "R1 err");
    expect_port(P_REQ, 32'h0, "R1 sys_rst_req");

    // R2 request coding
    wr(8'h04, 32'h5);
    expect_port(P_REQ, 32'h0, "R2 non-true code");
    expect_rd(8'h04, 32'h5, "R2 stored code");
    wr(8'h04, 32'h6);
    expect_port(P_REQ, 32'h1, "R2 true code");

    // R3 completion
    tick(); rst_done_evt = 1'b1; tick(); rst_done_evt = 1'b0;
    expect_port(P_REQ, 32'h0, "R3 request dropped");
    expect_rd(8'h04, 32'h9, "R3 field false");
    expect_rd(8'h08, 32'h05, "R3 sw cause logged");

    // R4/R5 cause bits
    tick(); hw_req_evt = 5'b10010; tick(); hw_req_evt = '0;
    expect_rd(8'h08, 32'h95, "R5 hw causes set");
    wr(8'h08, 32'hFF);
    expect_rd(8'h08, 32'h90, "R4 w1c low bits only");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h2; lp_exit_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; lp_exit_evt = 1'b0;
    expect_rd(8'h08, 32'h92, "R5 set beats clear");
    wr(8'h08, 32'h2);
    expect_rd(8'h08, 32'h90, "R4 clear lp bit");

    // R12 alert test
    wr(8'h00, 32'h1);
    expect_port(P_PULSE, 32'h1, "R12 fatal pulse");
    tick();
    expect_port(P_PULSE, 32'h0, "R12 pulse one cycle");
    wr(8'h00, 32'h2);
    expect_port(P_PULSE, 32'h2, "R12 cnsty pulse");
    expect_rd(8'h00, 32'h0, "R12 reads zero");

    // R7 software resets
    wr(swc(2), 32'h0);
    expect_port(P_SWRST, 32'hFB, "R7 hold ch2");
    wr(swc(5), 32'h0);
    expect_port(P_SWRST, 32'hDB, "R7 hold ch5");
    wr(swc(2), 32'h1);
    expect_port(P_SWRST, 32'hDF, "R7 release ch2");

    // R6 lock behaviour
    wr(swl(5), 32'h1);
    expect_rd(swl(5), 32'h1, "R6 write one keeps lock");
    wr(swl(5), 32'h0);
    expect_rd(swl(5), 32'h0, "R6 write zero clears");
    wr(swl(5), 32'h1);
    expect_rd(swl(5), 32'h0, "R6 stays cleared");
    wr(swc(5), 32'h1);
    expect_port(P_SWRST, 32'hDF, "R7 locked ch5 ignored");
    expect_rd(swc(5), 32'h0, "R7 locked readback");
    wr(swc(6), 32'h0);
    expect_port(P_SWRST, 32'h9F, "R7 neighbour still free");

    // R8 dump control
    wr(8'h10, 32'h71);
    expect_port(P_ADUMP, 32'h0F, "R8 alert en/idx");
    expect_rd(8'h10, 32'h71, "R8 alert readback");
    wr(8'h20, 32'hA1);
    expect_port(P_CDUMP, 32'h15, "R8 cpu en/idx");
    expect_rd(8'h20, 32'hA1, "R8 cpu readback");

    // R11 attributes/data
    alert_dump_cnt = 4'hC; alert_dump_word = 32'hDEADBEEF;
    cpu_dump_cnt = 4'h3; cpu_dump_word = 32'h12345678;
    expect_rd(8'h14, 32'hC, "R11 alert count");
    expect_rd(8'h18, 32'hDEADBEEF, "R11 alert word");
    expect_rd(8'h24, 32'h3, "R11 cpu count");
    expect_rd(8'h28, 32'h12345678, "R11 cpu word");

    // R10 system reset
    tick(); sys_rst_evt = 1'b1; tick(); sys_rst_evt = 1'b0;
    expect_rd(8'h10, 32'h70, "R10 alert en cleared");
    expect_rd(8'h20, 32'hA0, "R10 cpu en cleared");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h31; sys_rst_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; sys_rst_evt = 1'b0;
    expect_rd(8'h10, 32'h30, "R10 wins over write");

    // R9 locked window
    wr(8'h1C, 32'h0);
    wr(8'h20, 32'h51);
    expect_rd(8'h20, 32'hA0, "R9 cpu write ignored");
    expect_port(P_CDUMP, 32'h14, "R9 cpu outputs held");
    wr(8'h10, 32'h21);
    expect_rd(8'h10, 32'h21, "R9 alert window free");

    // R13 errors
    tick(); err_evt = 3'b101; tick(); err_evt = '0;
    expect_rd(8'h6C, 32'h5, "R13 errors set");
    wr(8'h6C, 32'h0);
    expect_rd(8'h6C, 32'h5, "R13 write no effect");
    tick(); err_evt = 3'b010; tick(); err_evt = '0;
    expect_rd(8'h6C, 32'h7, "R13 accumulate");

    tick();
    wait (sb_q.size() == 0);
    #2;
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule